// File: doc/BRIEF.md
# Timer Interrupt Flag Controller

This block keeps the pending-event flags of an eight-channel capture/compare timer and of the timer's 16-bit free-running counter. The capture and compare datapaths sit outside the block. Each channel reports an event as a single-cycle pulse, and that pulse raises the channel's flag. The block holds the counter itself and advances it on a clock-enable tick. It raises an overflow flag on the tick where the counter wraps from all ones to zero.

Software reaches the flags through a simple register port. One strobe is one access, and every access completes in the cycle it is presented. There is no back-pressure: no valid/ready pair is used, and the port never stalls. Reads return the flags. Writing ones clears flags. When the fast-clear input is high, a flag can also be cleared as a side effect of normal traffic:
- reading a capture channel's register clears that channel's flag;
- writing a compare channel's register clears that channel's flag;
- touching the counter clears the overflow flag.

A single registered interrupt line combines the flags with per-flag enables.

Address map (parameters, defaults in brackets):
- channel window at `CH_BASE` [0x20], two bytes per channel, so channel n lives at `CH_BASE+2n` and `CH_BASE+2n+1`;
- counter at `CNT_ADDR` [0x30], high byte at the even address and low byte at the odd one;
- channel-flag register at `FLG_ADDR` [0x34], with the overflow-flag register at `FLG_ADDR+1`.

Top module: `tfc_flag_ctrl`

## Requirements
- R1: While `rst_n` is low, all channel flags, the overflow flag, the counter and `irq` are 0.
- R2: A pulse on `ch_event[n]` makes `ch_flags[n]` read 1 after the next rising edge. A byte read at `FLG_ADDR` returns channel n in bit n. A byte read at `FLG_ADDR+1` returns the overflow flag in bit 7 and zeros in bits 6..0.
- R3: A byte write at `FLG_ADDR` clears each channel flag whose data bit is 1 and leaves flags with a 0 bit unchanged. A write at `FLG_ADDR+1` with data bit 7 set clears the overflow flag.
- R4: The counter advances by one only in cycles where `tick` is 1. The overflow flag is set exactly on the tick that takes the counter from 0xFFFF to 0x0000, and never otherwise.
- R5: With `fast_clr_en` high, an access to either byte of channel n's pair clears flag n in two cases: a read when `ch_is_oc[n]`=0 (capture channel), or a write when `ch_is_oc[n]`=1 (compare channel). An access in the other direction leaves the flag unchanged.
- R6: With `fast_clr_en` high, any read or write of `CNT_ADDR` or `CNT_ADDR+1` clears the overflow flag.
- R7: With `fast_clr_en` low, channel-window and counter accesses do not change any flag.
- R8: If a flag's set event and a clear of that flag fall in the same cycle, the flag ends up 1.
- R9: `irq` is 1 in a cycle exactly when, in the previous cycle, some `ch_flags[n] & ch_ie[n]` or `ovf_flag & ovf_ie` was 1.
- R10: When `bus_word` is 1, the access covers the aligned byte pair (address bit 0 is ignored) with the even byte in data bits 15..8. It is one access and clears a flag once. A word read at `FLG_ADDR` returns {channel flags, overflow byte}. A word read at `CNT_ADDR` returns the counter. Writes to the counter do not change its value.
- R11: `bus_rdata` is combinational and shows the state before any clear caused by the same access. It is 0 when no read is strobed, for channel-window reads, and for unmapped addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Counter clock enable |
| ch_event | input | 8 | Single-cycle channel event pulses |
| ch_is_oc | input | 8 | 1 = channel works as compare, 0 = capture |
| fast_clr_en | input | 1 | Enables clear-on-access |
| ch_ie | input | 8 | Channel interrupt enables |
| ovf_ie | input | 1 | Overflow interrupt enable |
| bus_sel | input | 1 | Access strobe, one access per cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_word | input | 1 | 1 = 16-bit aligned access |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 16 | Write data (byte access uses 7..0) |
| bus_rdata | output | 16 | Read data |
| cnt_value | output | 16 | Free-running counter value |
| ch_flags | output | 8 | Channel flags |
| ovf_flag | output | 1 | Overflow flag |
| irq | output | 1 | Registered combined interrupt |

## Verification
The flags are driven with set patterns that overlap, and clearing masks are chosen to hit set bits and already-clear bits alike. This separates a true write-one-to-clear from a plain register load or from toggling. Fast clear is tried in the four combinations of read/write against capture/compare channels, at even and odd byte addresses, and as word accesses at odd addresses. These cases expose a wrong channel index, a wrong direction rule and double clears. A long run of ticks over the wrap shows that overflow rises only at the 0xFFFF edge. Simultaneous set and clear, together with deliberate mask changes, pin down the priority and the one-cycle interrupt lag.

// File: rtl/tfc_pkg.sv
package tfc_pkg;
  typedef enum logic [1:0] {
    REG_NONE,
    REG_CHAN,
    REG_CNT,
    REG_FLAG
  } tfc_region_e;
endpackage

// File: rtl/tfc_counter.sv
module tfc_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);
  // wrap marks the tick that carries the counter out of all ones
  assign wrap = tick && (&cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (tick) cnt <= cnt + CNT_W'(1);
  end
endmodule

// File: rtl/tfc_bus_decode.sv
module tfc_bus_decode
  import tfc_pkg::*;
#(
  parameter int NUM_CH   = 8,
  parameter int CNT_W    = 16,
  parameter int ADDR_W   = 8,
  parameter int CH_BASE  = 'h20,
  parameter int CNT_ADDR = 'h30,
  parameter int FLG_ADDR = 'h34
) (
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic              bus_word,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [15:0]       bus_wdata,
  input  logic              fast_clr_en,
  input  logic [NUM_CH-1:0] ch_is_oc,
  input  logic [NUM_CH-1:0] ch_flags,
  input  logic              ovf_flag,
  input  logic [CNT_W-1:0]  cnt,
  output logic [NUM_CH-1:0] ch_clr,
  output logic              ovf_clr,
  output logic [15:0]       bus_rdata
);
  localparam int CH_SPAN = 2 * NUM_CH;

  logic [ADDR_W-1:0] addr_eff;
  int                addr_i;
  int                ch_off;
  tfc_region_e       region;
  logic [7:0]        flg1_byte;
  logic [7:0]        flg2_byte;
  logic [7:0]        wr_clr1;
  logic              ovf_wr;
  logic [15:0]       cnt16;

  // region decode on the aligned address
  always_comb begin
    addr_eff = bus_word ? {bus_addr[ADDR_W-1:1], 1'b0} : bus_addr;
    addr_i   = int'(addr_eff);
    ch_off   = addr_i - CH_BASE;
    if (ch_off >= 0 && ch_off < CH_SPAN)      region = REG_CHAN;
    else if ((addr_i >> 1) == (CNT_ADDR >> 1)) region = REG_CNT;
    else if ((addr_i >> 1) == (FLG_ADDR >> 1)) region = REG_FLAG;
    else                                       region = REG_NONE;
  end

  // flag register images
  always_comb begin
    flg1_byte = '0;
    for (int i = 0; i < NUM_CH; i++) flg1_byte[i] = ch_flags[i];
    flg2_byte = {ovf_flag, 7'b0};
  end

  // write-one-to-clear decode; FLG_ADDR is even
  always_comb begin
    wr_clr1 = '0;
    ovf_wr  = 1'b0;
    if (bus_sel && bus_wr && region == REG_FLAG) begin
      if (bus_word) begin
        wr_clr1 = bus_wdata[15:8];
        ovf_wr  = bus_wdata[7];
      end else if (!addr_eff[0]) begin
        wr_clr1 = bus_wdata[7:0];
      end else begin
        ovf_wr  = bus_wdata[7];
      end
    end
  end

  // per-channel clear: explicit write or fast clear by direction
  for (genvar g = 0; g < NUM_CH; g++) begin : g_chclr
    logic hit;
    logic fast;
    assign hit        = bus_sel && (region == REG_CHAN) && ((ch_off >>> 1) == g);
    assign fast       = fast_clr_en && hit && (bus_wr == ch_is_oc[g]);
    assign ch_clr[g]  = wr_clr1[g] | fast;
  end

  assign ovf_clr = ovf_wr | (fast_clr_en && bus_sel && region == REG_CNT);

  // read mux
  always_comb begin
    cnt16            = '0;
    cnt16[CNT_W-1:0] = cnt;
    bus_rdata        = '0;
    if (bus_sel && !bus_wr) begin
      unique case (region)
        REG_CNT: begin
          if (bus_word)         bus_rdata = cnt16;
          else if (addr_eff[0]) bus_rdata = {8'h00, cnt16[7:0]};
          else                  bus_rdata = {8'h00, cnt16[15:8]};
        end
        REG_FLAG: begin
          if (bus_word)         bus_rdata = {flg1_byte, flg2_byte};
          else if (addr_eff[0]) bus_rdata = {8'h00, flg2_byte};
          else                  bus_rdata = {8'h00, flg1_byte};
        end
        default: bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/tfc_flag_bank.sv
module tfc_flag_bank #(
  parameter int N = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flags
);
  // one cell per flag; a set in the same cycle as a clear wins
  for (genvar g = 0; g < N; g++) begin : g_cell
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        flags[g] <= 1'b0;
      else if (set_i[g]) flags[g] <= 1'b1;
      else if (clr_i[g]) flags[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/tfc_irq.sv
module tfc_irq #(
  parameter int N = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] flags,
  input  logic [N-1:0] en,
  output logic         irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= |(flags & en);
  end
endmodule

// File: rtl/tfc_flag_ctrl.sv
module tfc_flag_ctrl #(
  parameter int NUM_CH   = 8,
  parameter int CNT_W    = 16,
  parameter int ADDR_W   = 8,
  parameter int CH_BASE  = 'h20,
  parameter int CNT_ADDR = 'h30,
  parameter int FLG_ADDR = 'h34
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [NUM_CH-1:0] ch_event,
  input  logic [NUM_CH-1:0] ch_is_oc,
  input  logic              fast_clr_en,
  input  logic [NUM_CH-1:0] ch_ie,
  input  logic              ovf_ie,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic              bus_word,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [15:0]       bus_wdata,
  output logic [15:0]       bus_rdata,
  output logic [CNT_W-1:0]  cnt_value,
  output logic [NUM_CH-1:0] ch_flags,
  output logic              ovf_flag,
  output logic              irq
);
  localparam int NFLAG = NUM_CH + 1;

  logic              wrap;
  logic [NUM_CH-1:0] ch_clr;
  logic              ovf_clr;
  logic [NFLAG-1:0]  all_flags;

  tfc_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cnt(cnt_value), .wrap(wrap)
  );

  tfc_bus_decode #(
    .NUM_CH(NUM_CH), .CNT_W(CNT_W), .ADDR_W(ADDR_W),
    .CH_BASE(CH_BASE), .CNT_ADDR(CNT_ADDR), .FLG_ADDR(FLG_ADDR)
  ) u_dec (
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_word(bus_word),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .fast_clr_en(fast_clr_en), .ch_is_oc(ch_is_oc),
    .ch_flags(ch_flags), .ovf_flag(ovf_flag), .cnt(cnt_value),
    .ch_clr(ch_clr), .ovf_clr(ovf_clr), .bus_rdata(bus_rdata)
  );

  tfc_flag_bank #(.N(NFLAG)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .set_i({wrap, ch_event}), .clr_i({ovf_clr, ch_clr}),
    .flags(all_flags)
  );

  assign ch_flags = all_flags[NUM_CH-1:0];
  assign ovf_flag = all_flags[NUM_CH];

  tfc_irq #(.N(NFLAG)) u_irq (
    .clk(clk), .rst_n(rst_n), .flags(all_flags), .en({ovf_ie, ch_ie}), .irq(irq)
  );
endmodule

module tfc_flag_chk #(
  parameter int NUM_CH = 8,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic [NUM_CH-1:0] ch_event,
  input logic              fast_clr_en,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [CNT_W-1:0]  cnt_value,
  input logic [NUM_CH-1:0] ch_flags,
  input logic              ovf_flag,
  input logic [NUM_CH-1:0] ch_ie,
  input logic              irq
);
  assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|ch_event) |=> ((ch_flags & $past(ch_event)) == $past(ch_event)));

  assert_ovf_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && (&cnt_value)) |=> (ovf_flag && cnt_value == '0));

  assert_cnt_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt_value));

  assert_no_false_ovf_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ovf_flag && !(tick && (&cnt_value))) |=> !ovf_flag);

  assert_no_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!fast_clr_en && !(bus_sel && bus_wr)) |=> ((ch_flags & $past(ch_flags)) == $past(ch_flags)));

  assert_irq_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_flags == '0 && !ovf_flag) |=> !irq);

  assert_irq_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((ch_flags & ch_ie) != '0) |=> irq);
endmodule

bind tfc_flag_ctrl tfc_flag_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .ch_event(ch_event),
  .fast_clr_en(fast_clr_en), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .cnt_value(cnt_value), .ch_flags(ch_flags), .ovf_flag(ovf_flag),
  .ch_ie(ch_ie), .irq(irq)
);

// File: tb/test_tfc_flag_ctrl.sv
module test_tfc_flag_ctrl;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int CH_BASE  = 'h20;
  localparam int CNT_ADDR = 'h30;
  localparam int FLG_ADDR = 'h34;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic [7:0]  ch_event = '0;
  logic [7:0]  ch_is_oc = '0;
  logic        fast_clr_en = 1'b0;
  logic [7:0]  ch_ie = '0;
  logic        ovf_ie = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_word = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [15:0] cnt_value;
  logic [7:0]  ch_flags;
  logic        ovf_flag;
  logic        irq;

  tfc_flag_ctrl i_tfc_flag_ctrl (
    .clk(clk), .rst_n(rst_n), .tick(tick), .ch_event(ch_event),
    .ch_is_oc(ch_is_oc), .fast_clr_en(fast_clr_en), .ch_ie(ch_ie),
    .ovf_ie(ovf_ie), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_word(bus_word), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .cnt_value(cnt_value), .ch_flags(ch_flags),
    .ovf_flag(ovf_flag), .irq(irq)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic [15:0] last_rd;

  // reference model state
  int        cnt_m = 0;
  bit [7:0]  chf_m = '0;
  bit        ovf_m = 1'b0;
  bit        irq_m = 1'b0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    bit [7:0] clr;
    bit       oclr;
    bit       irq_n;
    int       a;
    int       off;
    if (!rst_n) begin
      cnt_m = 0; chf_m = '0; ovf_m = 1'b0; irq_m = 1'b0;
    end else begin
      irq_n = ((chf_m & ch_ie) != 0) || (ovf_m && ovf_ie);
      clr = '0; oclr = 1'b0;
      a = bus_word ? (int'(bus_addr) & ~1) : int'(bus_addr);
      off = a - CH_BASE;
      if (bus_sel) begin
        if (bus_wr && a == FLG_ADDR) begin
          clr = bus_word ? bus_wdata[15:8] : bus_wdata[7:0];
          if (bus_word && bus_wdata[7]) oclr = 1'b1;
        end
        if (bus_wr && a == FLG_ADDR + 1 && bus_wdata[7]) oclr = 1'b1;
        if (fast_clr_en) begin
          if (off >= 0 && off < 16 && (bus_wr == ch_is_oc[off/2])) clr[off/2] = 1'b1;
          if (a == CNT_ADDR || a == CNT_ADDR + 1) oclr = 1'b1;
        end
      end
      chf_m = ch_event | (chf_m & ~clr);
      ovf_m = (tick && cnt_m == 65535) || (ovf_m && !oclr);
      if (tick) cnt_m = (cnt_m + 1) % 65536;
      irq_m = irq_n;
    end
  end

  function automatic logic [15:0] rd_model();
    int a;
    logic [15:0] c;
    c = 16'(cnt_m);
    if (!bus_sel || bus_wr) return 16'h0;
    a = bus_word ? (int'(bus_addr) & ~1) : int'(bus_addr);
    if (a == CNT_ADDR)     return bus_word ? c : {8'h00, c[15:8]};
    if (a == CNT_ADDR + 1) return {8'h00, c[7:0]};
    if (a == FLG_ADDR)     return bus_word ? {chf_m, ovf_m, 7'b0} : {8'h00, chf_m};
    if (a == FLG_ADDR + 1) return {8'h00, ovf_m, 7'b0};
    return 16'h0;
  endfunction

  // inputs change at posedge+1; rdata sampled mid-cycle; state after edge
  task automatic step(string tag);
    #2;
    last_rd = bus_rdata;
    chk({tag, " rdata R11"}, bus_rdata, rd_model());
    @(posedge clk);
    #1;
    chk({tag, " counter R4"}, cnt_value, cnt_m);
    chk({tag, " flags R2"}, ch_flags, chf_m);
    chk({tag, " ovf R4"}, ovf_flag, ovf_m);
    chk({tag, " irq R9"}, irq, irq_m);
  endtask

  task automatic acc(bit wr, bit word, int addr, logic [15:0] d, string tag);
    bus_sel = 1'b1; bus_wr = wr; bus_word = word;
    bus_addr = 8'(addr); bus_wdata = d;
    step(tag);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_word = 1'b0; bus_wdata = '0;
  endtask

  task automatic ev(logic [7:0] e);
    ch_event = e;
    step("event R2");
    ch_event = '0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected under 190000", cyc);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("reset flags R1", ch_flags, 8'h00);
    chk("reset ovf R1", ovf_flag, 1'b0);
    chk("reset counter R1", cnt_value, 16'h0000);
    chk("reset irq R1", irq, 1'b0);
    rst_n = 1'b1;
    step("idle");

    // R2 set and read layout
    ev(8'hA5);
    chk("set pattern R2", ch_flags, 8'hA5);
    acc(0, 0, FLG_ADDR, 16'h0, "read flg1");
    chk("flag byte R2", last_rd, 16'h00A5);
    acc(0, 0, FLG_ADDR + 1, 16'h0, "read flg2");
    chk("ovf byte R2", last_rd, 16'h0000);

    // R3 write-one-to-clear
    acc(1, 0, FLG_ADDR, 16'h0005, "w1c");
    chk("w1c R3", ch_flags, 8'hA0);
    acc(1, 0, FLG_ADDR, 16'h0000, "w0");
    chk("write zero R3", ch_flags, 8'hA0);

    // R9 registered interrupt
    ch_ie = 8'h80;
    step("mask");
    chk("irq on R9", irq, 1'b1);
    acc(1, 0, FLG_ADDR, 16'h0080, "clr7");
    chk("irq lag R9", irq, 1'b1);
    step("after clr");
    chk("irq off R9", irq, 1'b0);
    ch_ie = 8'h00;

    // R5 fast clear by direction
    fast_clr_en = 1'b1;
    ch_is_oc = 8'h0F;
    ev(8'hFF);
    acc(0, 0, CH_BASE + 10, 16'h0, "rd ch5 cap");
    chk("capture read clears R5", ch_flags, 8'hDF);
    acc(1, 0, CH_BASE + 5, 16'h0, "wr ch2 oc");
    chk("compare write clears R5", ch_flags, 8'hDB);
    acc(0, 0, CH_BASE + 2, 16'h0, "rd ch1 oc");
    chk("compare read keeps R5", ch_flags, 8'hDB);
    acc(1, 0, CH_BASE + 12, 16'h0, "wr ch6 cap");
    chk("capture write keeps R5", ch_flags, 8'hDB);

    // R7 fast clear disabled
    fast_clr_en = 1'b0;
    acc(0, 0, CH_BASE + 14, 16'h0, "rd ch7 off");
    chk("no fast clear read R7", ch_flags, 8'hDB);
    acc(1, 0, CH_BASE + 0, 16'h0, "wr ch0 off");
    chk("no fast clear write R7", ch_flags, 8'hDB);

    // R8 set beats clear
    ch_event = 8'h08;
    acc(1, 0, FLG_ADDR, 16'h0008, "set+clr");
    ch_event = 8'h00;
    chk("set wins R8", ch_flags, 8'hDB);

    // R10 word accesses
    fast_clr_en = 1'b1;
    acc(1, 1, CH_BASE + 6, 16'hFFFF, "word wr ch3");
    chk("word clear once R10", ch_flags, 8'hD3);
    acc(0, 1, FLG_ADDR, 16'h0, "word rd flags");
    chk("word flag read R10", last_rd, 16'hD300);
    acc(0, 1, CH_BASE + 9, 16'h0, "word rd odd ch4");
    chk("aligned word R10", ch_flags, 8'hC3);

    // R11 unmapped read
    acc(0, 0, 'h40, 16'h0, "unmapped");
    chk("unmapped read R11", last_rd, 16'h0000);
    chk("unmapped no effect R11", ch_flags, 8'hC3);

    // R4 counter and overflow
    fast_clr_en = 1'b0;
    step("no tick");
    chk("hold without tick R4", cnt_value, 16'h0000);
    tick = 1'b1;
    while (cnt_m != 65535) step("run");
    chk("no ovf before wrap R4", ovf_flag, 1'b0);
    step("wrap");
    chk("ovf at wrap R4", ovf_flag, 1'b1);
    chk("counter wrapped R4", cnt_value, 16'h0000);
    step("t1");
    step("t2");
    step("t3");
    tick = 1'b0;
    chk("counter after wrap R4", cnt_value, 16'h0003);

    // R7 counter access without fast clear
    acc(0, 0, CNT_ADDR + 1, 16'h0, "rd cnt off");
    chk("counter read keeps ovf R7", ovf_flag, 1'b1);
    chk("counter low byte R10", last_rd, 16'h0003);
    acc(1, 0, FLG_ADDR + 1, 16'h007F, "w0 ovf");
    chk("ovf write zero R3", ovf_flag, 1'b1);
    acc(0, 1, CNT_ADDR, 16'h0, "word rd cnt");
    chk("word counter read R10", last_rd, 16'h0003);

    ovf_ie = 1'b1;
    step("ovf ie");
    chk("ovf irq R9", irq, 1'b1);

    // R6 fast clear through counter access
    fast_clr_en = 1'b1;
    acc(1, 1, CNT_ADDR, 16'hFFFF, "word wr cnt");
    chk("counter access clears ovf R6", ovf_flag, 1'b0);
    chk("counter not written R10", cnt_value, 16'h0003);
    step("tail");
    chk("ovf irq drops R9", irq, 1'b0);

    finish_run();
  end
endmodule